// File: doc/BRIEF.md
# SD Data FIFO Byte Packer

This block sits between a 32-bit register port and a byte-wide card data path. Its core is a 16-word circular FIFO. When the block receives from the card, incoming bytes are gathered into words and pushed into the FIFO. The first byte goes in the least significant position. When the block sends to the card, words are popped from the FIFO and sent one byte at a time, low byte first.

Software writes a bytes-per-block value and then a block count. Writing the block count loads a remaining-byte counter with the product of the two. The transfer runs until that counter reaches zero. A transfer that ends partway through a word still pushes that word, with its unused upper bytes zero. The block raises a data-moved flag, an optional data interrupt and, while sending, a block-boundary interrupt. It also reports the FIFO fill level in a debug register.

Top module: `sd_fifo_packer`

## Requirements
- R1: The FIFO holds 16 words of 32 bits in first-in first-out order. A push while it holds 16 words is dropped. A pop while it is empty changes nothing and returns zero.
- R2: A write to the block-count register (address 5) loads the remaining-byte counter with the written count times the bytes-per-block register (address 4). Exactly that many bytes then cross the card interface.
- R3: While receiving, byte k of each group of four lands at bits 8k+7:8k of a word, and the word is pushed after its fourth byte. card_rx_ready stays low while the FIFO holds 16 words.
- R4: When the remaining count runs out in the middle of a word, that word is pushed with its unfilled upper bytes zero.
- R5: While sending, each popped word is presented on card_tx_byte low byte first. Each byte accepted (card_tx_valid and card_tx_ready high together) decrements the remaining count. card_tx_valid drops once the FIFO is empty and the current word is used up.
- R6: Every word moved by the engine sets status bit 0. It also sets status bit 8 when config bit 4 is set. Writing ones to the status register (address 2) clears those bits. irq is high while status bit 8 or bit 9 is set.
- R7: When the remaining count reaches zero through a transfer, debug bits 3:0 become 1.
- R8: While sending, status bit 9 is set after a byte when config bit 8 is set, the block size is nonzero and the remaining count is a whole multiple of the block size.
- R9: Debug bits 8:4 always read as the current FIFO fill level.
- R10: The debug register (address 3) reads 0x0000C60F after reset. A software write whose bits 3:0 are 0xF stores 0 in that field.
- R11: Register map: 0 data (a read pops a word, a write pushes one), 1 config, 2 status, 3 debug, 4 bytes per block, 5 block count, 6 direction (bit 0 receive, bit 1 send; receive wins if both are set). Read data appears on reg_rdata in the cycle after the reg_rd strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, registered |
| card_rx_valid | input | 1 | Card offers a received byte |
| card_rx_byte | input | 8 | Received byte |
| card_rx_ready | output | 1 | Block accepts a received byte |
| card_tx_valid | output | 1 | Block offers a byte to send |
| card_tx_byte | output | 8 | Byte to send |
| card_tx_ready | input | 1 | Card accepts the byte |
| irq | output | 1 | Interrupt request |

## Verification
The receive path is driven with three byte streams: a whole number of words, a length that ends partway through a word, and a stream longer than the FIFO with no reads. The first checks lane order. The second checks the zero fill of the partial word. The third checks that the stall and resume lose no bytes and repeat none. The send path is driven with two words ready at once, a single word, and a transfer left starved of data partway through. These show byte order, the block-boundary flag with and without its enable, and that sending stops on an empty FIFO and resumes after a push. Pushing 17 words with no transfer running, then popping 17, separates dropped overflow from wraparound corruption.

// File: rtl/sdfp_pkg.sv
`timescale 1ns/1ps
package sdfp_pkg;
   typedef enum logic [2:0] {
      SEL_DATA  = 3'd0,
      SEL_CFG   = 3'd1,
      SEL_STAT  = 3'd2,
      SEL_DBG   = 3'd3,
      SEL_BSIZE = 3'd4,
      SEL_BCNT  = 3'd5,
      SEL_DIR   = 3'd6
   } reg_sel_e;

   localparam int STB_MOVED   = 0;
   localparam int STB_DATA_IRQ = 8;
   localparam int STB_BLK_IRQ  = 9;
   localparam int CFB_DATA_IE  = 4;
   localparam int CFB_BLK_IE   = 8;

   localparam int          FILL_W          = 5;
   localparam logic [31:0] DBG_RESET_VAL   = 32'h0000_C60F;
   localparam logic [3:0]  DBG_STATE_DATA  = 4'h1;
endpackage

// File: rtl/sdfp_fifo.sv
`timescale 1ns/1ps
module sdfp_fifo #(
   parameter int DEPTH = 16,
   parameter int WIDTH = 32,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = PTR_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] push_data,
   input  logic             pop,
   output logic [WIDTH-1:0] head,
   output logic [CNT_W-1:0] count,
   output logic             full,
   output logic             empty
);
   logic [WIDTH-1:0] mem [DEPTH];
   logic [PTR_W-1:0] rd_ptr_q;
   logic [PTR_W-1:0] wr_ptr;
   logic             push_ok, pop_ok;

   initial begin : p_param_chk
      assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0)
         else $error("sdfp_fifo: DEPTH must be a power of two");
   end

   assign full    = (count == CNT_W'(DEPTH));
   assign empty   = (count == '0);
   assign push_ok = push && !full;
   assign pop_ok  = pop && !empty;
   assign wr_ptr  = rd_ptr_q + count[PTR_W-1:0];
   assign head    = empty ? '0 : mem[rd_ptr_q];

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr_q <= '0;
         count    <= '0;
      end else begin
         if (pop_ok) rd_ptr_q <= rd_ptr_q + 1'b1;
         count <= count + CNT_W'(push_ok) - CNT_W'(pop_ok);
      end
   end

   a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH));
   a_r1_full_push_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop) |=> $stable(count));
   a_r1_empty_pop_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && pop) |-> (head == '0));
endmodule

// File: rtl/sdfp_rx_pack.sv
`timescale 1ns/1ps
module sdfp_rx_pack #(
   parameter int BYTES = 4,
   localparam int IDX_W = $clog2(BYTES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               restart,
   input  logic               take,
   input  logic [7:0]         byte_in,
   input  logic               last,
   output logic               word_push,
   output logic [8*BYTES-1:0] word_out
);
   logic [IDX_W-1:0] idx_q;

   initial begin : p_param_chk
      assert (BYTES >= 2 && (BYTES & (BYTES - 1)) == 0)
         else $error("sdfp_rx_pack: BYTES must be a power of two");
   end

   assign word_push = take && (idx_q == IDX_W'(BYTES - 1) || last);

   for (genvar k = 0; k < BYTES; k++) begin : g_lane
      logic [7:0] lane_val;
      if (k < BYTES - 1) begin : g_store
         logic [7:0] acc_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) acc_q <= '0;
            else if (take && idx_q == IDX_W'(k)) acc_q <= byte_in;
         end
         assign lane_val = (idx_q == IDX_W'(k)) ? byte_in :
                           (idx_q >  IDX_W'(k)) ? acc_q : 8'h00;
      end else begin : g_top
         assign lane_val = (idx_q == IDX_W'(k)) ? byte_in : 8'h00;
      end
      assign word_out[8*k +: 8] = lane_val;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         idx_q <= '0;
      else if (restart)   idx_q <= '0;
      else if (word_push) idx_q <= '0;
      else if (take)      idx_q <= idx_q + 1'b1;
   end

   a_r4_restart_lane0: assert property (@(posedge clk) disable iff (!rst_n)
      word_push |=> (idx_q == '0));
endmodule

// File: rtl/sdfp_tx_unpack.sv
`timescale 1ns/1ps
module sdfp_tx_unpack #(
   parameter int BYTES = 4,
   localparam int LEFT_W = $clog2(BYTES + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [8*BYTES-1:0] load_word,
   input  logic               send,
   input  logic               abort,
   output logic               have,
   output logic [7:0]         byte_out
);
   logic [8*BYTES-1:0] shift_q;
   logic [LEFT_W-1:0]  left_q;

   assign have     = (left_q != '0);
   assign byte_out = shift_q[7:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shift_q <= '0;
         left_q  <= '0;
      end else if (abort) begin
         left_q  <= '0;
      end else if (load) begin
         shift_q <= load_word;
         left_q  <= LEFT_W'(BYTES);
      end else if (send && have) begin
         shift_q <= shift_q >> 8;
         left_q  <= left_q - 1'b1;
      end
   end

   a_r5_left_bound: assert property (@(posedge clk) disable iff (!rst_n)
      left_q <= LEFT_W'(BYTES));
endmodule

// File: rtl/sd_fifo_packer.sv
`timescale 1ns/1ps
module sd_fifo_packer
   import sdfp_pkg::*;
#(
   parameter int FIFO_DEPTH = 16,
   parameter int BSIZE_W    = 12,
   parameter int BCNT_W     = 9
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_wr,
   input  logic        reg_rd,
   input  logic [2:0]  reg_addr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   input  logic        card_rx_valid,
   input  logic [7:0]  card_rx_byte,
   output logic        card_rx_ready,
   output logic        card_tx_valid,
   output logic [7:0]  card_tx_byte,
   input  logic        card_tx_ready,
   output logic        irq
);
   localparam int BYTES = 4;
   localparam int REM_W = BSIZE_W + BCNT_W;
   localparam int CNT_W = $clog2(FIFO_DEPTH) + 1;

   initial begin : p_param_chk
      assert (CNT_W <= FILL_W) else $error("sd_fifo_packer: fill level wider than debug field");
      assert (BSIZE_W <= 32 && BCNT_W <= 32) else $error("sd_fifo_packer: size fields exceed 32 bits");
   end

   reg_sel_e sel;
   assign sel = reg_sel_e'(reg_addr);

   logic               cfg_data_ie_q, cfg_blk_ie_q;
   logic [1:0]         dir_q;
   logic [BSIZE_W-1:0] bsize_q, blk_left_q;
   logic [BCNT_W-1:0]  bcnt_q;
   logic [REM_W-1:0]   rem_q;
   logic               st_moved_q, st_dirq_q, st_blk_q;
   logic [31:9]        dbg_hi_q;
   logic [3:0]         dbg_state_q;

   logic        wr_data, rd_data, load_cnt, wr_stat, wr_dbg;
   logic        rx_mode, tx_mode, rem_nz, rem_last;
   logic        rx_take, tx_send, tx_load, tx_have, tx_abort, byte_move;
   logic        pk_push, blk_edge, word_moved;
   logic [31:0] pk_word, fifo_head;
   logic [CNT_W-1:0] fifo_count;
   logic        fifo_full, fifo_empty, fifo_push, fifo_pop;
   logic [31:0] fifo_wdata;

   assign wr_data  = reg_wr && sel == SEL_DATA;
   assign rd_data  = reg_rd && sel == SEL_DATA;
   assign load_cnt = reg_wr && sel == SEL_BCNT;
   assign wr_stat  = reg_wr && sel == SEL_STAT;
   assign wr_dbg   = reg_wr && sel == SEL_DBG;

   assign rx_mode  = dir_q[0];
   assign tx_mode  = dir_q[1] && !dir_q[0];
   assign rem_nz   = (rem_q != '0);
   assign rem_last = (rem_q == REM_W'(1));

   // receive side: card bytes into packer, words into FIFO
   assign card_rx_ready = rx_mode && rem_nz && !fifo_full && !wr_data && !load_cnt;
   assign rx_take       = card_rx_ready && card_rx_valid;

   sdfp_rx_pack #(.BYTES(BYTES)) u_pack (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart   (load_cnt),
      .take      (rx_take),
      .byte_in   (card_rx_byte),
      .last      (rem_last),
      .word_push (pk_push),
      .word_out  (pk_word)
   );

   // send side: FIFO words into unpacker, bytes to card
   assign tx_load   = tx_mode && rem_nz && !tx_have && !fifo_empty && !rd_data && !load_cnt;
   assign tx_send   = card_tx_valid && card_tx_ready;
   assign byte_move = rx_take || tx_send;
   assign tx_abort  = load_cnt || (byte_move && rem_last);

   sdfp_tx_unpack #(.BYTES(BYTES)) u_unpack (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (tx_load),
      .load_word (fifo_head),
      .send      (tx_send),
      .abort     (tx_abort),
      .have      (tx_have),
      .byte_out  (card_tx_byte)
   );
   assign card_tx_valid = tx_have;

   assign fifo_push  = wr_data || pk_push;
   assign fifo_wdata = wr_data ? reg_wdata : pk_word;
   assign fifo_pop   = rd_data || tx_load;

   sdfp_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(32)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (fifo_push),
      .push_data (fifo_wdata),
      .pop       (fifo_pop),
      .head      (fifo_head),
      .count     (fifo_count),
      .full      (fifo_full),
      .empty     (fifo_empty)
   );

   assign word_moved = pk_push || tx_load;
   assign blk_edge   = tx_send && (blk_left_q == BSIZE_W'(1)) && (bsize_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_data_ie_q <= 1'b0;
         cfg_blk_ie_q  <= 1'b0;
         dir_q         <= '0;
         bsize_q       <= '0;
         bcnt_q        <= '0;
      end else if (reg_wr) begin
         case (sel)
            SEL_CFG: begin
               cfg_data_ie_q <= reg_wdata[CFB_DATA_IE];
               cfg_blk_ie_q  <= reg_wdata[CFB_BLK_IE];
            end
            SEL_DIR:   dir_q   <= reg_wdata[1:0];
            SEL_BSIZE: bsize_q <= reg_wdata[BSIZE_W-1:0];
            SEL_BCNT:  bcnt_q  <= reg_wdata[BCNT_W-1:0];
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q      <= '0;
         blk_left_q <= '0;
      end else if (load_cnt) begin
         rem_q      <= REM_W'(reg_wdata[BCNT_W-1:0]) * REM_W'(bsize_q);
         blk_left_q <= bsize_q;
      end else begin
         if (byte_move) rem_q <= rem_q - 1'b1;
         if (tx_send)   blk_left_q <= (blk_left_q == BSIZE_W'(1)) ? bsize_q : blk_left_q - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_moved_q <= 1'b0;
         st_dirq_q  <= 1'b0;
         st_blk_q   <= 1'b0;
      end else begin
         st_moved_q <= (st_moved_q && !(wr_stat && reg_wdata[STB_MOVED]))    || word_moved;
         st_dirq_q  <= (st_dirq_q  && !(wr_stat && reg_wdata[STB_DATA_IRQ])) || (word_moved && cfg_data_ie_q);
         st_blk_q   <= (st_blk_q   && !(wr_stat && reg_wdata[STB_BLK_IRQ]))  || (blk_edge && cfg_blk_ie_q);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dbg_hi_q    <= DBG_RESET_VAL[31:9];
         dbg_state_q <= DBG_RESET_VAL[3:0];
      end else if (wr_dbg) begin
         dbg_hi_q    <= reg_wdata[31:9];
         dbg_state_q <= (reg_wdata[3:0] == 4'hF) ? 4'h0 : reg_wdata[3:0];
      end else if (byte_move && rem_last) begin
         dbg_state_q <= DBG_STATE_DATA;
      end
   end

   assign irq = st_dirq_q || st_blk_q;

   logic [31:0] rd_mux;
   always_comb begin
      rd_mux = '0;
      case (sel)
         SEL_DATA: rd_mux = fifo_head;
         SEL_CFG: begin
            rd_mux[CFB_DATA_IE] = cfg_data_ie_q;
            rd_mux[CFB_BLK_IE]  = cfg_blk_ie_q;
         end
         SEL_STAT: begin
            rd_mux[STB_MOVED]    = st_moved_q;
            rd_mux[STB_DATA_IRQ] = st_dirq_q;
            rd_mux[STB_BLK_IRQ]  = st_blk_q;
         end
         SEL_DBG:   rd_mux = {dbg_hi_q, FILL_W'(fifo_count), dbg_state_q};
         SEL_BSIZE: rd_mux = 32'(bsize_q);
         SEL_BCNT:  rd_mux = 32'(bcnt_q);
         SEL_DIR:   rd_mux = 32'(dir_q);
         default:   rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      reg_rdata <= '0;
      else if (reg_rd) reg_rdata <= rd_mux;
   end

   a_r2_rem_step: assert property (@(posedge clk) disable iff (!rst_n)
      !load_cnt |=> (rem_q == $past(rem_q) || rem_q == $past(rem_q) - REM_W'(1)));
   a_r5_tx_needs_count: assert property (@(posedge clk) disable iff (!rst_n)
      card_tx_valid |-> rem_nz);
   a_r8_blk_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st_blk_q) |-> ($past(cfg_blk_ie_q) && $past(bsize_q) != '0));
   a_r3_no_rx_when_full: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_count == CNT_W'(FIFO_DEPTH)) |-> !(card_rx_valid && card_rx_ready));
endmodule

// File: tb/sd_fifo_packer_tb.sv
`timescale 1ns/1ps
module sd_fifo_packer_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        card_rx_valid = 1'b0;
   logic [7:0]  card_rx_byte = '0;
   logic        card_rx_ready;
   logic        card_tx_valid;
   logic [7:0]  card_tx_byte;
   logic        card_tx_ready = 1'b0;
   logic        irq;

   int checks = 0, errors = 0;
   logic [7:0] src [0:127];
   int src_idx = 0;
   logic [7:0] got [0:63];
   int got_n = 0;

   always #10 clk = ~clk;

   sd_fifo_packer dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .card_rx_valid(card_rx_valid),
      .card_rx_byte(card_rx_byte), .card_rx_ready(card_rx_ready), .card_tx_valid(card_tx_valid),
      .card_tx_byte(card_tx_byte), .card_tx_ready(card_tx_ready), .irq(irq)
   );

   localparam logic [2:0] A_DATA = 3'd0, A_CFG = 3'd1, A_STAT = 3'd2, A_DBG = 3'd3,
                          A_BSIZE = 3'd4, A_BCNT = 3'd5, A_DIR = 3'd6;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk); reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk); reg_rd = 1'b1; reg_addr = a;
      @(negedge clk); reg_rd = 1'b0;
      #1 d = reg_rdata;
   endtask

   task automatic feed(input int cycles);
      for (int c = 0; c < cycles; c++) begin
         @(negedge clk); card_rx_valid = 1'b1; card_rx_byte = src[src_idx];
         #1 if (card_rx_ready) src_idx++;
      end
      @(negedge clk); card_rx_valid = 1'b0;
   endtask

   task automatic drain(input int cycles);
      for (int c = 0; c < cycles; c++) begin
         @(negedge clk); card_tx_ready = 1'b1;
         #1 if (card_tx_valid) begin got[got_n] = card_tx_byte; got_n++; end
      end
      @(negedge clk); card_tx_ready = 1'b0;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rd(A_DBG, v);  check("R10 debug reset value", v, 32'h0000C60F);
      rd(A_STAT, v); check("R6 status after reset", v, 32'h0);
      check("R6 irq after reset", 32'(irq), 32'h0);
      rd(A_DATA, v); check("R1 empty pop returns zero", v, 32'h0);
      wr(A_BSIZE, 32'h123); rd(A_BSIZE, v); check("R11 bytes-per-block readback", v, 32'h123);
   endtask

   task automatic t_read_pack();
      logic [31:0] v;
      for (int i = 0; i < 8; i++) src[i] = 8'(8'h11 * (i + 1));
      src_idx = 0;
      wr(A_CFG, 32'h10); wr(A_DIR, 32'h3); wr(A_BSIZE, 32'd4); wr(A_BCNT, 32'd2);
      feed(20);
      check("R2 bytes accepted equals count times size", 32'(src_idx), 32'd8);
      check("R11 receive wins over send", 32'(card_tx_valid), 32'h0);
      rd(A_DBG, v);
      check("R9 fill level field", (v >> 4) & 32'h1F, 32'd2);
      check("R7 state forced to data mode", v & 32'hF, 32'h1);
      rd(A_STAT, v); check("R6 moved flag and data irq", v, 32'h101);
      check("R6 irq raised", 32'(irq), 32'h1);
      rd(A_DATA, v); check("R3 first packed word", v, 32'h44332211);
      rd(A_DATA, v); check("R3 second packed word", v, 32'h88776655);
      wr(A_STAT, 32'h301); rd(A_STAT, v); check("R6 write-one clear", v, 32'h0);
      check("R6 irq cleared", 32'(irq), 32'h0);
   endtask

   task automatic t_partial();
      logic [31:0] v;
      for (int i = 0; i < 6; i++) src[i] = 8'(8'hA1 + i);
      src_idx = 0;
      wr(A_CFG, 32'h0); wr(A_DIR, 32'h1); wr(A_BSIZE, 32'd6); wr(A_BCNT, 32'd1);
      feed(15);
      check("R2 six bytes accepted", 32'(src_idx), 32'd6);
      rd(A_DATA, v); check("R3 full word of partial transfer", v, 32'hA4A3A2A1);
      rd(A_DATA, v); check("R4 partial word upper bytes zero", v, 32'h0000A6A5);
      rd(A_STAT, v); check("R6 moved flag without data irq", v, 32'h001);
      wr(A_STAT, 32'h301);
   endtask

   task automatic t_full();
      logic [31:0] v;
      for (int i = 0; i < 68; i++) src[i] = 8'(i * 3 + 1);
      src_idx = 0;
      wr(A_DIR, 32'h1); wr(A_BSIZE, 32'd4); wr(A_BCNT, 32'd17);
      feed(100);
      check("R3 stall at sixteen words", 32'(src_idx), 32'd64);
      @(negedge clk); card_rx_valid = 1'b1; #1
      check("R3 ready low while full", 32'(card_rx_ready), 32'h0);
      card_rx_valid = 1'b0;
      rd(A_DBG, v); check("R9 fill level sixteen", (v >> 4) & 32'h1F, 32'd16);
      rd(A_DATA, v); check("R3 word 0 after stall", v, {src[3], src[2], src[1], src[0]});
      feed(20);
      check("R2 transfer resumes and ends", 32'(src_idx), 32'd68);
      for (int w = 1; w < 17; w++) begin
         rd(A_DATA, v);
         check($sformatf("R1 order word %0d", w), v,
               {src[4*w+3], src[4*w+2], src[4*w+1], src[4*w]});
      end
      rd(A_DATA, v); check("R1 pop after drain returns zero", v, 32'h0);
      wr(A_STAT, 32'h301);
   endtask

   task automatic t_overflow();
      logic [31:0] v;
      wr(A_DIR, 32'h0);
      for (int i = 0; i < 17; i++) wr(A_DATA, 32'h1000 + i);
      rd(A_DBG, v); check("R9 fill level capped", (v >> 4) & 32'h1F, 32'd16);
      for (int i = 0; i < 16; i++) begin
         rd(A_DATA, v); check($sformatf("R1 overflow order %0d", i), v, 32'h1000 + i);
      end
      rd(A_DATA, v); check("R1 seventeenth push dropped", v, 32'h0);
   endtask

   task automatic t_debug();
      logic [31:0] v;
      wr(A_DBG, 32'h1234567F); rd(A_DBG, v); check("R10 nibble F stored as zero", v, 32'h12345600);
      wr(A_DBG, 32'h00000A03); rd(A_DBG, v); check("R10 other nibble kept", v, 32'h00000A03);
   endtask

   task automatic t_write_unpack();
      logic [31:0] v;
      logic [7:0] exp [0:7];
      exp = '{8'hAA, 8'hBB, 8'hCC, 8'hDD, 8'h11, 8'h22, 8'h33, 8'h44};
      got_n = 0;
      wr(A_CFG, 32'h110); wr(A_DIR, 32'h2); wr(A_BSIZE, 32'd4); wr(A_BCNT, 32'd2);
      wr(A_DATA, 32'hDDCCBBAA); wr(A_DATA, 32'h44332211);
      drain(30);
      check("R5 byte count sent", 32'(got_n), 32'd8);
      for (int i = 0; i < 8; i++) check($sformatf("R5 send byte %0d", i), 32'(got[i]), 32'(exp[i]));
      rd(A_STAT, v); check("R8 block irq with enable", v, 32'h301);
      check("R6 irq from block flag", 32'(irq), 32'h1);
      wr(A_STAT, 32'h301);
   endtask

   task automatic t_write_noblk();
      logic [31:0] v;
      got_n = 0;
      wr(A_CFG, 32'h010); wr(A_BSIZE, 32'd4); wr(A_BCNT, 32'd1);
      wr(A_DATA, 32'h87654321);
      drain(15);
      check("R5 single word bytes", 32'(got_n), 32'd4);
      rd(A_STAT, v); check("R8 no block irq when disabled", v, 32'h101);
      wr(A_STAT, 32'h301);
   endtask

   task automatic t_write_starve();
      logic [31:0] v;
      got_n = 0;
      wr(A_CFG, 32'h0); wr(A_DBG, 32'h00000A03); wr(A_BSIZE, 32'd8); wr(A_BCNT, 32'd1);
      wr(A_DATA, 32'h0D0C0B0A);
      drain(20);
      check("R5 stops when FIFO empty", 32'(got_n), 32'd4);
      check("R5 valid low when starved", 32'(card_tx_valid), 32'h0);
      rd(A_DBG, v); check("R7 state kept mid-transfer", v, 32'h00000A03);
      wr(A_DATA, 32'h04030201);
      drain(20);
      check("R5 resumes after push", 32'(got_n), 32'd8);
      check("R5 resumed low byte", 32'(got[4]), 32'h01);
      check("R5 resumed high byte", 32'(got[7]), 32'h04);
      rd(A_DBG, v); check("R7 state set at zero count", v, 32'h00000A01);
   endtask

   initial begin : watchdog
      #(20 * 150000);
      errors++; checks++;
      $display("FAIL watchdog all actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_read_pack();
      t_partial();
      t_full();
      t_overflow();
      t_debug();
      t_write_unpack();
      t_write_noblk();
      t_write_starve();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule